// File: doc/BRIEF.md
# One-Hot Selected Flip-Flop Register File

This block is a small storage array made of plain flip-flops, where both the write side and the read side pick entries with one-hot select vectors instead of binary addresses. It suits designs where the logic driving it already produces one select line per entry, so no address decoder or encoder is needed anywhere in the path.

On the write side, each select bit acts directly as the load enable of one entry. On the read side, each entry is gated by its own select bit and all the gated words are ORed together. No select position has priority over another. The result is captured in an output register on the rising clock edge.

When reads are not enabled, the output register holds all ones. An asynchronous disable input forces the output to all ones immediately, without waiting for a clock edge. A combinational flag reports any read select that is not exactly one-hot, so the surrounding logic or a bench can spot malformed selects.

The default build has 32 entries of 4 bits each, so both select vectors are 32 bits wide.

Top module: `onehot_regfile`

## Requirements
- R1: On a rising clock edge with `wr_en` high, entry i loads `wr_data` exactly when `wr_sel[i]` is 1. All other entries keep their value.
- R2: When `wr_sel` has several bits set together with `wr_en`, every selected entry receives the same `wr_data` in that cycle.
- R3: On a rising clock edge with `rd_en` high, `rd_data` captures the entry chosen by a one-hot `rd_sel`. The value appears after that edge.
- R4: A read with `rd_en` high and `rd_sel` all zeros captures all zeros.
- R5: A read whose `rd_sel` has several bits set captures the bitwise OR of the selected entries. This is normal behaviour, not an error.
- R6: On a rising clock edge with `rd_en` low, `rd_data` becomes all ones.
- R7: While `mem_off` is 1, `rd_data` is all ones at once, with no clock edge needed. Stored entries are not altered by `mem_off`.
- R8: A write and a read of the same entry on the same edge return the old contents. The new value is returned by the next read.
- R9: With `wr_en` low, no entry changes, whatever `wr_sel` holds.
- R10: `sel_bad` is 1, combinationally, whenever `rd_sel` does not have exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mem_off | input | 1 | Asynchronous disable; forces `rd_data` to all ones |
| wr_en | input | 1 | Write enable |
| wr_sel | input | NUM_ENTRIES | One-hot write select, one bit per entry |
| wr_data | input | DATA_W | Data to write |
| rd_en | input | 1 | Read enable; when low the output loads all ones |
| rd_sel | input | NUM_ENTRIES | One-hot read select |
| rd_data | output | DATA_W | Registered read data |
| sel_bad | output | 1 | High when `rd_sel` is not exactly one-hot |

## Verification
The bench first uses single-bit selects on both ports to show that each entry is written and read on its own lane. It then uses all-zero read selects, to separate the AND-OR network from a priority chain or a default value, and multi-bit read and write selects, to show the OR merge and the broadcast write. Same-cycle write and read of one entry separates old-data from write-through behaviour. Toggling `mem_off` between clock edges separates an asynchronous override from a synchronous one.

// File: rtl/onehot_rf_pkg.sv
package onehot_rf_pkg;
    localparam int unsigned DEF_ENTRIES = 32;
    localparam int unsigned DEF_DATA_W  = 4;
endpackage

// File: rtl/orf_store.sv
module orf_store #(
    parameter int unsigned NUM_ENTRIES = onehot_rf_pkg::DEF_ENTRIES,
    parameter int unsigned DATA_W      = onehot_rf_pkg::DEF_DATA_W
) (
    input  logic                                clk,
    input  logic                                wr_en,
    input  logic [NUM_ENTRIES-1:0]              wr_sel,
    input  logic [DATA_W-1:0]                   wr_data,
    output logic [NUM_ENTRIES-1:0][DATA_W-1:0]  cells
);
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cell
        // each select line is the load enable of one entry
        always_ff @(posedge clk) begin
            if (wr_en && wr_sel[g]) begin
                cells[g] <= wr_data;
            end
        end

        // R1 / R2: selected entry holds the written word afterwards
        a_r1_load: assert property (@(posedge clk)
            (wr_en && wr_sel[g]) |=> (cells[g] == $past(wr_data)));

        // R9: without a selecting write the entry is untouched
        a_r9_hold: assert property (@(posedge clk)
            !(wr_en && wr_sel[g]) |=> $stable(cells[g]));
    end
endmodule

// File: rtl/orf_andor.sv
module orf_andor #(
    parameter int unsigned NUM_ENTRIES = onehot_rf_pkg::DEF_ENTRIES,
    parameter int unsigned DATA_W      = onehot_rf_pkg::DEF_DATA_W
) (
    input  logic [NUM_ENTRIES-1:0][DATA_W-1:0]  cells,
    input  logic [NUM_ENTRIES-1:0]              sel,
    output logic [DATA_W-1:0]                   merged,
    output logic                                not_onehot
);
    logic [NUM_ENTRIES:0][DATA_W-1:0] acc;
    logic [NUM_ENTRIES:0]             seen;
    logic [NUM_ENTRIES:0]             multi;

    assign acc[0]   = '0;
    assign seen[0]  = 1'b0;
    assign multi[0] = 1'b0;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_lane
        // mask each word with its replicated select bit, then OR
        assign acc[g+1]   = acc[g] | (cells[g] & {DATA_W{sel[g]}});
        assign seen[g+1]  = seen[g] | sel[g];
        assign multi[g+1] = multi[g] | (seen[g] & sel[g]);
    end

    assign merged     = acc[NUM_ENTRIES];
    assign not_onehot = !seen[NUM_ENTRIES] || multi[NUM_ENTRIES];

    // R10: flag agrees with a population count of the select
    always_comb begin
        a_r10_flag: assert (($countones(sel) == 1) != not_onehot);
    end
endmodule

// File: rtl/onehot_regfile.sv
module onehot_regfile #(
    parameter int unsigned NUM_ENTRIES = onehot_rf_pkg::DEF_ENTRIES,
    parameter int unsigned DATA_W      = onehot_rf_pkg::DEF_DATA_W
) (
    input  logic                   clk,
    input  logic                   mem_off,
    input  logic                   wr_en,
    input  logic [NUM_ENTRIES-1:0] wr_sel,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   rd_en,
    input  logic [NUM_ENTRIES-1:0] rd_sel,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   sel_bad
);
    localparam logic [DATA_W-1:0] IDLE_WORD = '1;

    logic [NUM_ENTRIES-1:0][DATA_W-1:0] cells;
    logic [DATA_W-1:0]                  merged;

    orf_store #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cells   (cells)
    );

    orf_andor #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W)) u_andor (
        .cells      (cells),
        .sel        (rd_sel),
        .merged     (merged),
        .not_onehot (sel_bad)
    );

    // output register: asynchronous force to the idle word
    always_ff @(posedge clk or posedge mem_off) begin
        if (mem_off) begin
            rd_data <= IDLE_WORD;
        end else if (rd_en) begin
            rd_data <= merged;
        end else begin
            rd_data <= IDLE_WORD;
        end
    end

    // R6: a cycle without read enable leaves the idle word
    a_r6_idle_ones: assert property (@(posedge clk) disable iff (mem_off)
        !rd_en |=> (rd_data == IDLE_WORD));

    // R7: disable held across an edge means the output is already idle
    a_r7_forced: assert property (@(posedge clk)
        mem_off |-> (rd_data == IDLE_WORD));

    // R4: empty select on a read gives zeros
    a_r4_empty_zero: assert property (@(posedge clk) disable iff (mem_off)
        (rd_en && (rd_sel == '0)) |=> (rd_data == '0));
endmodule

// File: tb/onehot_regfile_tb.sv
`timescale 1ns/1ps
module onehot_regfile_tb;
    localparam int N = 32;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         mem_off;
    logic         wr_en;
    logic [N-1:0] wr_sel;
    logic [W-1:0] wr_data;
    logic         rd_en;
    logic [N-1:0] rd_sel;
    logic [W-1:0] rd_data;
    logic         sel_bad;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model [N];

    always #2 clk = ~clk;

    onehot_regfile #(.NUM_ENTRIES(N), .DATA_W(W)) u_dut (
        .clk(clk), .mem_off(mem_off), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .sel_bad(sel_bad)
    );

    function automatic logic [W-1:0] exp_read(logic [N-1:0] s);
        logic [W-1:0] r = '0;
        for (int i = 0; i < N; i++) if (s[i]) r = r | model[i];
        return r;
    endfunction

    function automatic logic exp_flag(logic [N-1:0] s);
        int c = 0;
        for (int i = 0; i < N; i++) if (s[i]) c++;
        return c != 1;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycle(string req, logic we, logic [N-1:0] ws, logic [W-1:0] wd,
                         logic re, logic [N-1:0] rs);
        logic [W-1:0] e;
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_data = wd; rd_en = re; rd_sel = rs;
        #0.5;
        check("R10 flag", {{(W-1){1'b0}}, sel_bad}, {{(W-1){1'b0}}, exp_flag(rs)});
        e = re ? exp_read(rs) : '1;
        @(posedge clk);
        if (we) for (int i = 0; i < N; i++) if (ws[i]) model[i] = wd;
        #0.5;
        check(req, rd_data, e);
    endtask

    function automatic logic [N-1:0] pick_sel();
        int k = $urandom_range(0, 9);
        if (k < 7) return N'(1) << $urandom_range(0, N-1);
        if (k == 7) return '0;
        return N'($urandom);
    endfunction

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        mem_off = 1'b1; wr_en = 0; wr_sel = '0; wr_data = '0; rd_en = 0; rd_sel = '0;
        #5;
        check("R7 reset idle", rd_data, '1);
        @(negedge clk); mem_off = 1'b0;
        // R1: fill every entry through single-bit selects
        for (int i = 0; i < N; i++) cycle("R1 fill", 1, N'(1) << i, W'(i * 7 + 3), 0, '0);
        for (int i = 0; i < N; i++) cycle("R3 read", 0, '0, '0, 1, N'(1) << i);
        cycle("R4 empty read", 0, '0, '0, 1, '0);
        cycle("R5 multi read", 0, '0, '0, 1, 32'h0000_0006);
        cycle("R5 multi read all", 0, '0, '0, 1, '1);
        cycle("R6 idle", 0, '0, '0, 0, 32'h1);
        // R2: broadcast write then read each lane back
        cycle("R2 broadcast", 1, 32'h8000_0011, 4'hA, 0, '0);
        cycle("R2 lane0", 0, '0, '0, 1, 32'h1);
        cycle("R2 lane4", 0, '0, '0, 1, 32'h10);
        cycle("R2 lane31", 0, '0, '0, 1, 32'h8000_0000);
        // R8: same-edge write and read
        cycle("R8 old data", 1, 32'h4, 4'h5, 1, 32'h4);
        cycle("R8 new data", 0, '0, '0, 1, 32'h4);
        // R9: select without enable
        cycle("R9 no write", 0, 32'h4, 4'hC, 0, '0);
        cycle("R9 readback", 0, '0, '0, 1, 32'h4);
        // R7: asynchronous force between edges, contents kept
        cycle("R3 pre-off", 0, '0, '0, 1, 32'h2);
        @(negedge clk); #0.5;
        mem_off = 1'b1; #0.5;
        check("R7 async ones", rd_data, '1);
        @(posedge clk); #0.5;
        check("R7 held", rd_data, '1);
        mem_off = 1'b0;
        check("R7 stays until edge", rd_data, '1);
        cycle("R7 contents kept", 0, '0, '0, 1, 32'h2);
        // random mix
        for (int it = 0; it < 400; it++)
            cycle("R3 random", $urandom_range(0, 1) == 1, pick_sel(), W'($urandom),
                  $urandom_range(0, 3) != 0, pick_sel());
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule